// File: doc/BRIEF.md
# Carry-Forced Adder ALU

This block is a small combinational ALU. It is made from a ripple chain of identical one-bit adder cells and has no separate logic unit. Arithmetic uses the chain in the usual way: the carry ripples from the least significant cell to the most significant cell. For subtraction, the B operand is inverted and a carry of one is injected at the bottom of the chain.

The bitwise operations come from the same cells. The carry that links the cells is cut. Every cell instead receives a constant incoming carry of 0 or 1. The result bit is then taken from either the cell's sum output or its carry output. With a forced 0, the sum outputs give exclusive-or and the carry outputs give AND. With a forced 1, the sum outputs give exclusive-nor and the carry outputs give OR.

The operand width and the internal form of the cell are parameters. An elaboration check rejects a width of zero.

Top module: `carry_forced_alu`

## Requirements
- R1: With op_sel = 3'b000 (add), result equals (opd_a + opd_b + carry_in) modulo 2^WIDTH, and carry_out equals bit WIDTH of that sum.
- R2: With op_sel = 3'b001 (subtract), result equals (opd_a - opd_b) modulo 2^WIDTH. carry_out is 1 exactly when opd_a >= opd_b as unsigned values. carry_in has no effect on either output.
- R3: With op_sel = 3'b010, result equals opd_a XOR opd_b.
- R4: With op_sel = 3'b011, result equals the bitwise complement of (opd_a XOR opd_b).
- R5: With op_sel = 3'b100, result equals opd_a AND opd_b.
- R6: With op_sel = 3'b101, result equals opd_a OR opd_b.
- R7: For op_sel codes 3'b010 through 3'b101, carry_out is 0 and carry_in has no effect on result.
- R8: For op_sel codes 3'b110 and 3'b111, result is all zeros and carry_out is 0, whatever the operands and carry_in are.
- R9: In every cell, when the two operand bits are equal, the cell's carry output equals that shared bit. When they differ, it equals the cell's incoming carry.
- R10: In every cell, the sum output is the complement of the incoming carry when the half sum (A XOR B) is 1, and equals the incoming carry when the half sum is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0, used by add only |
| op_sel | input | 3 | Operation code |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the top cell for add and subtract, 0 otherwise |

## Verification
The in-design checks are immediate checks on combinational values. They assume that every input carries a defined 0 or 1 and that the logic has settled before a check is evaluated. The bench drives every input to a known value in every step. It waits a fixed delay before it samples any output. The bench sweeps all operand pairs together with both carry-in values, so the forced-carry paths and the ripple path are both exercised under every bit pattern. It also drives the two unused operation codes, so the decoder never sees an undriven or unknown opcode.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'b000,
      OP_SUB  = 3'b001,
      OP_XOR  = 3'b010,
      OP_XNOR = 3'b011,
      OP_AND  = 3'b100,
      OP_OR   = 3'b101
   } op_e;

   // Cell implementation variants
   localparam int CELL_RULE = 0;  // mux form: select on half sum
   localparam int CELL_GATE = 1;  // gate form: xor/and-or equations

   typedef struct packed {
      logic valid;       // opcode recognised
      logic ripple;      // link cells through the carry chain
      logic invert_b;    // complement operand B
      logic seed_one;    // chain seed forced to 1 (else carry_in)
      logic force_val;   // constant carry fed to every cell when not rippling
      logic take_carry;  // result from cell carry output instead of sum
   } ctl_t;

endpackage

// File: rtl/alu_ctl.sv
module alu_ctl
   import alu_pkg::*;
(
   input  logic [OP_W-1:0] op_sel,
   output ctl_t            ctl
);

   always_comb begin
      ctl = '0;
      unique case (op_sel)
         OP_ADD: begin
            ctl.valid  = 1'b1;
            ctl.ripple = 1'b1;
         end
         OP_SUB: begin
            ctl.valid    = 1'b1;
            ctl.ripple   = 1'b1;
            ctl.invert_b = 1'b1;
            ctl.seed_one = 1'b1;
         end
         OP_XOR: begin
            ctl.valid = 1'b1;
         end
         OP_XNOR: begin
            ctl.valid     = 1'b1;
            ctl.force_val = 1'b1;
         end
         OP_AND: begin
            ctl.valid      = 1'b1;
            ctl.take_carry = 1'b1;
         end
         OP_OR: begin
            ctl.valid      = 1'b1;
            ctl.force_val  = 1'b1;
            ctl.take_carry = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

   // R8: unknown codes must never be flagged valid
   always_comb begin
      if (op_sel[2] && op_sel[1]) begin
         a_r8_ctl_invalid: assert (!ctl.valid && !ctl.ripple);
      end
   end

   // Rippling and forcing are exclusive uses of the cell carry input
   always_comb begin
      if (ctl.ripple) begin
         a_r7_ripple_no_force: assert (!ctl.force_val && !ctl.take_carry);
      end
   end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
   import alu_pkg::*;
#(
   parameter int STYLE = CELL_GATE
) (
   input  logic a,
   input  logic b,
   input  logic cin,
   output logic sum,
   output logic cout
);

   logic half;

   assign half = a ^ b;

   generate
      if (STYLE == CELL_RULE) begin : g_rule
         assign sum  = half ? ~cin : cin;
         assign cout = half ? cin  : a;
      end else if (STYLE == CELL_GATE) begin : g_gate
         assign sum  = a ^ b ^ cin;
         assign cout = (a & b) | (half & cin);
      end else begin : g_bad
         $error("alu_bit_cell: STYLE %0d not supported", STYLE);
      end
   endgenerate

   // R9: equal operand bits generate or kill; differing bits propagate
   always_comb begin
      if (a == b) begin
         a_r9_carry_shared: assert (cout == a);
      end else begin
         a_r9_carry_prop: assert (cout == cin);
      end
   end

   // R10: sum follows or inverts the incoming carry under the half sum
   always_comb begin
      if (half) begin
         a_r10_sum_invert: assert (sum == !cin);
      end else begin
         a_r10_sum_follow: assert (sum == cin);
      end
   end

endmodule

// File: rtl/alu_result_pick.sv
module alu_result_pick
   import alu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  ctl_t             ctl,
   input  logic [WIDTH-1:0] sums,
   input  logic [WIDTH-1:0] carries,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int TOP = WIDTH - 1;

   always_comb begin
      if (!ctl.valid)          result = '0;
      else if (ctl.take_carry) result = carries;
      else                     result = sums;
   end

   assign carry_out = ctl.valid & ctl.ripple & carries[TOP];

   // R8: an unrecognised opcode gives a zero result
   always_comb begin
      if (!ctl.valid) begin
         a_r8_zero_result: assert (result == '0 && !carry_out);
      end
   end

   // R7: no carry is reported for the bitwise operations
   always_comb begin
      if (!ctl.ripple) begin
         a_r7_no_carry_out: assert (!carry_out);
      end
   end

endmodule

// File: rtl/carry_forced_alu.sv
module carry_forced_alu
   import alu_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int CELL_STYLE = CELL_GATE
) (
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic             carry_in,
   input  logic [OP_W-1:0]  op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);

   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 1) begin : g_width_check
         $error("carry_forced_alu: WIDTH must be at least 1");
      end
   endgenerate

   ctl_t             ctl;
   logic             seed;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] cell_cin;
   logic [WIDTH-1:0] cell_sum;
   logic [WIDTH-1:0] cell_cout;

   alu_ctl u_ctl (
      .op_sel (op_sel),
      .ctl    (ctl)
   );

   assign seed  = ctl.seed_one ? 1'b1 : carry_in;
   assign b_eff = ctl.invert_b ? ~opd_b : opd_b;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         if (i == 0) begin : g_low
            assign cell_cin[i] = ctl.ripple ? seed : ctl.force_val;
         end else begin : g_up
            assign cell_cin[i] = ctl.ripple ? cell_cout[i-1] : ctl.force_val;
         end

         alu_bit_cell #(
            .STYLE (CELL_STYLE)
         ) u_cell (
            .a    (opd_a[i]),
            .b    (b_eff[i]),
            .cin  (cell_cin[i]),
            .sum  (cell_sum[i]),
            .cout (cell_cout[i])
         );
      end
   endgenerate

   alu_result_pick #(
      .WIDTH (WIDTH)
   ) u_pick (
      .ctl       (ctl),
      .sums      (cell_sum),
      .carries   (cell_cout),
      .result    (result),
      .carry_out (carry_out)
   );

   // R3 .. R6: bitwise results from the forced-carry cells
   always_comb begin
      case (op_sel)
         OP_XOR:  a_r3_xor:  assert (result == (opd_a ^ opd_b));
         OP_XNOR: a_r4_xnor: assert (result == ~(opd_a ^ opd_b));
         OP_AND:  a_r5_and:  assert (result == (opd_a & opd_b));
         OP_OR:   a_r6_or:   assert (result == (opd_a | opd_b));
         default: ;
      endcase
   end

   // R2: the top carry of a subtraction reports no-borrow
   always_comb begin
      if (op_sel == OP_SUB) begin
         a_r2_no_borrow: assert (carry_out == (opd_a >= opd_b));
      end
   end

   // R1: the add result bits match the reference sum
   always_comb begin
      if (op_sel == OP_ADD) begin
         a_r1_add_sum: assert ({carry_out, result} ==
                               ({1'b0, opd_a} + {1'b0, opd_b} + {{WIDTH{1'b0}}, carry_in}));
      end
   end

   // bit TOP of the chain drives carry_out for arithmetic
   always_comb begin
      if (op_sel == OP_ADD || op_sel == OP_SUB) begin
         a_r1_top_carry: assert (carry_out == cell_cout[TOP]);
      end
   end

endmodule

// File: tb/carry_forced_alu_bench.sv
module carry_forced_alu_bench;

   localparam int W = 4;
   localparam int N = 1 << W;
   localparam int M = N - 1;

   logic         clk = 1'b0;
   logic [W-1:0] opd_a = '0;
   logic [W-1:0] opd_b = '0;
   logic         carry_in = 1'b0;
   logic [2:0]   op_sel = 3'b000;
   logic [W-1:0] result;
   logic         carry_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   carry_forced_alu #(.WIDTH(W)) u_carry_forced_alu (
      .opd_a     (opd_a),
      .opd_b     (opd_b),
      .carry_in  (carry_in),
      .op_sel    (op_sel),
      .result    (result),
      .carry_out (carry_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                  req, op_sel, opd_a, opd_b, carry_in, act, exp);
      end
   endtask

   task automatic apply(input int op, input int a, input int b, input int c);
      @(negedge clk);
      op_sel   = 3'(op);
      opd_a    = W'(a);
      opd_b    = W'(b);
      carry_in = 1'(c);
      #2;
   endtask

   // reset-like state: all inputs zero gives zero output
   task automatic t_idle;
      apply(0, 0, 0, 0);
      chk("R1 idle result", int'(result), 0);
      chk("R1 idle carry", int'(carry_out), 0);
   endtask

   task automatic t_add;
      for (int a = 0; a < N; a++)
         for (int b = 0; b < N; b++)
            for (int c = 0; c < 2; c++) begin
               int s;
               s = a + b + c;
               apply(0, a, b, c);
               chk("R1 add result", int'(result), s & M);
               chk("R1 add carry", int'(carry_out), (s >> W) & 1);
            end
   endtask

   task automatic t_sub;
      for (int a = 0; a < N; a++)
         for (int b = 0; b < N; b++)
            for (int c = 0; c < 2; c++) begin
               apply(1, a, b, c);
               chk("R2 sub result", int'(result), (a - b) & M);
               chk("R2 sub carry", int'(carry_out), (a >= b) ? 1 : 0);
            end
   endtask

   task automatic t_logic;
      for (int a = 0; a < N; a++)
         for (int b = 0; b < N; b++)
            for (int c = 0; c < 2; c++) begin
               apply(2, a, b, c);
               chk("R3 xor", int'(result), a ^ b);
               chk("R7 xor carry", int'(carry_out), 0);
               apply(3, a, b, c);
               chk("R4 xnor", int'(result), (~(a ^ b)) & M);
               chk("R7 xnor carry", int'(carry_out), 0);
               apply(4, a, b, c);
               chk("R5 and", int'(result), a & b);
               chk("R7 and carry", int'(carry_out), 0);
               apply(5, a, b, c);
               chk("R6 or", int'(result), a | b);
               chk("R7 or carry", int'(carry_out), 0);
            end
   endtask

   task automatic t_invalid;
      for (int op = 6; op < 8; op++)
         for (int a = 0; a < N; a += 5)
            for (int b = 0; b < N; b += 3)
               for (int c = 0; c < 2; c++) begin
                  apply(op, a, b, c);
                  chk("R8 invalid result", int'(result), 0);
                  chk("R8 invalid carry", int'(carry_out), 0);
               end
   endtask

   // corner cases: full overflow, borrow edge, carry_in ignored on subtract
   task automatic t_edges;
      apply(0, M, M, 1);
      chk("R1 max add result", int'(result), M);
      chk("R1 max add carry", int'(carry_out), 1);
      apply(0, M, 0, 1);
      chk("R1 full ripple result", int'(result), 0);
      chk("R1 full ripple carry", int'(carry_out), 1);
      apply(1, 0, 1, 1);
      chk("R2 borrow result", int'(result), M);
      chk("R2 borrow carry", int'(carry_out), 0);
      apply(1, 7, 7, 0);
      chk("R2 equal result", int'(result), 0);
      chk("R2 equal carry", int'(carry_out), 1);
   endtask

   initial begin
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_invalid();
      t_edges();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule